// File: doc/BRIEF.md
# Per-Chip DRAM Power-State Controller

This block governs the low-power state of a single, independently managed memory chip. It watches the request handshake and a pending-work flag for that chip. When the chip sits idle, the block lowers it through four power levels: Active, Standby, Nap and PowerDown. Any new work brings the chip back to Active. The request is held off until the wake-up delay of the level being left has run out.

Two policies are available. In quad-state mode the chip steps down one level at a time, each step after its own programmable idle threshold. In dual-state mode the chip drops straight from Active to a single configured base level as soon as it goes idle. An optional predictive mode works with quad-state operation. It records the length of the idle gap that ended at the last wake-up. If that gap exceeded a programmed benefit boundary, it sends the chip directly to PowerDown on the first idle cycle. All thresholds, latencies and the boundary are counted in clock cycles.

Top module: `dram_pwr_ctl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the state output is 00 (Active) and the request ready output is high.
- R2: A cycle is busy when req_valid or pending is high, and idle otherwise. In Active, a busy cycle keeps the chip in Active and clears its idle count.
- R3: In quad-state mode (mode_quad=1) the state moves from Active to Standby (code 01) at the clock edge that ends the (thr_as+1)-th consecutive idle cycle spent in Active.
- R4: In quad-state mode, Standby moves to Nap (code 10) after thr_sn+1 further consecutive idle cycles. Nap moves to PowerDown (code 11) after thr_np+1 further idle cycles. The idle count restarts at each step, and PowerDown holds while idle.
- R5: A busy cycle in Standby, Nap or PowerDown starts a wake-up with latency L, taken from lat_s, lat_n or lat_p for the level being left. The state output keeps the low code, and the chip neither demotes nor accepts work, until Active is reached exactly L+1 clock edges after that first busy cycle.
- R6: req_ready is high exactly when the state is Active, so a request is accepted only in state 00.
- R7: In dual-state mode (mode_quad=0) the first idle cycle in Active moves the chip to the base level given by base_sel (01 Standby, 10 Nap, 11 PowerDown; 00 is taken as Standby). The chip never goes deeper than that base level.
- R8: A threshold of zero makes the corresponding step happen on the first idle cycle. With all thresholds zero, codes 01, 10 and 11 appear on three consecutive edges.
- R9: With quad-state and pred_en=1, if the recorded gap is strictly greater than benefit, any idle cycle in Active, Standby or Nap moves the chip directly to PowerDown (11).
- R10: The recorded gap is the number of consecutive idle cycles just before the first busy cycle of a wake-up. It saturates at 2^CW-1 and is zero after reset. A gap equal to benefit does not trigger prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access request to this chip is offered |
| req_ready | output | 1 | Request accepted this cycle (chip is Active) |
| pending | input | 1 | Requests to this chip are still outstanding |
| mode_quad | input | 1 | 1: stepwise quad-state policy, 0: dual-state policy |
| pred_en | input | 1 | Enables gap-predicted direct drop to PowerDown |
| base_sel | input | 2 | Dual-state base level code |
| thr_as | input | CW | Idle cycles before Active to Standby |
| thr_sn | input | CW | Idle cycles before Standby to Nap |
| thr_np | input | CW | Idle cycles before Nap to PowerDown |
| lat_s | input | CW | Wake-up cycles from Standby |
| lat_n | input | CW | Wake-up cycles from Nap |
| lat_p | input | CW | Wake-up cycles from PowerDown |
| benefit | input | CW | Gap boundary above which prediction fires |
| state | output | 2 | Current level: 00 Active, 01 Standby, 10 Nap, 11 PowerDown |

## Verification
The assertions assume that a requester keeps req_valid high from the moment it raises it until the chip accepts it. They also assume that mode_quad, pred_en, base_sel and the thresholds change only while the chip is Active and busy. The stimulus follows both rules: every request is held until Active is seen, and each new configuration is applied after a forced return to Active with pending raised. The bench uses an 8-bit counter width, so that gap saturation can be reached within a short run.

// File: rtl/dram_pwr_ctl.sv
module dram_pwr_ctl #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          pending,
  input  logic          mode_quad,
  input  logic          pred_en,
  input  logic [1:0]    base_sel,
  input  logic [CW-1:0] thr_as,
  input  logic [CW-1:0] thr_sn,
  input  logic [CW-1:0] thr_np,
  input  logic [CW-1:0] lat_s,
  input  logic [CW-1:0] lat_n,
  input  logic [CW-1:0] lat_p,
  input  logic [CW-1:0] benefit,
  output logic [1:0]    state
);
  localparam logic [1:0] ACT = 2'd0;
  localparam logic [1:0] STB = 2'd1;
  localparam logic [1:0] PDN = 2'd3;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [1:0]    st;
  logic [CW-1:0] dwell, gap_run, gap_last, wcnt;
  logic          waking;
  logic [CW-1:0] thr_cur, lat_cur;

  wire       busy    = req_valid | pending;
  wire [1:0] base    = (base_sel == ACT) ? STB : base_sel;
  wire       predict = mode_quad & pred_en & (gap_last > benefit);
  wire       demote  = !busy && (st != PDN) &&
                       (predict || (mode_quad ? (dwell >= thr_cur) : (st == ACT)));
  wire [1:0] target  = predict ? PDN : (mode_quad ? st + 2'd1 : base);
  wire [CW-1:0] dwell_inc = (dwell == CMAX) ? dwell : dwell + ONE;

  always_comb begin
    case (st)
      2'd0:    thr_cur = thr_as;
      2'd1:    thr_cur = thr_sn;
      2'd2:    thr_cur = thr_np;
      default: thr_cur = CMAX;
    endcase
    case (st)
      2'd1:    lat_cur = lat_s;
      2'd2:    lat_cur = lat_n;
      2'd3:    lat_cur = lat_p;
      default: lat_cur = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ACT;
      dwell    <= '0;
      gap_run  <= '0;
      gap_last <= '0;
      wcnt     <= '0;
      waking   <= 1'b0;
    end else begin
      if (busy)                 gap_run <= '0;
      else if (gap_run != CMAX) gap_run <= gap_run + ONE;

      if (st == ACT) begin
        if (demote) begin
          st    <= target;
          dwell <= '0;
        end else begin
          dwell <= busy ? '0 : dwell_inc;
        end
      end else if (waking) begin
        if (wcnt == '0) begin
          st     <= ACT;
          waking <= 1'b0;
          dwell  <= '0;
        end else begin
          wcnt <= wcnt - ONE;
        end
      end else if (busy) begin
        gap_last <= gap_run;
        dwell    <= '0;
        if (lat_cur == '0) begin
          st <= ACT;
        end else begin
          waking <= 1'b1;
          wcnt   <= lat_cur - ONE;
        end
      end else if (demote) begin
        st    <= target;
        dwell <= '0;
      end else begin
        dwell <= dwell_inc;
      end
    end
  end

  assign state     = st;
  assign req_ready = (st == ACT);
endmodule

// File: rtl/dram_pwr_ctl_chk.sv
module dram_pwr_ctl_chk #(
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          pending,
  input logic          mode_quad,
  input logic          pred_en,
  input logic [CW-1:0] thr_as,
  input logic [1:0]    state
);
  a_r1_reset_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> state == 2'd0);

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && (req_valid || pending)) |=> state == 2'd0);

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_quad && !pred_en) |=>
      (state == 2'd0 || state == $past(state) || state == $past(state) + 2'd1));

  a_r5_request_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0 && req_valid) |=> (state == $past(state) || state == 2'd0));

  a_r7_base_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_quad && state != 2'd0) |=> (state == 2'd0 || state == $past(state)));

  a_r8_zero_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_quad && state == 2'd0 && thr_as == '0 && !req_valid && !pending)
      |=> state != 2'd0);
endmodule

bind dram_pwr_ctl dram_pwr_ctl_chk #(.CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pending(pending),
  .mode_quad(mode_quad), .pred_en(pred_en), .thr_as(thr_as), .state(state)
);

// File: tb/dram_pwr_ctl_test.sv
module dram_pwr_ctl_test;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, req_valid = 0, pending = 0, mode_quad = 0, pred_en = 0;
  logic [1:0] base_sel = 0;
  logic [CW-1:0] thr_as = 0, thr_sn = 0, thr_np = 0, lat_s = 0, lat_n = 0, lat_p = 0, benefit = 0;
  logic req_ready;
  logic [1:0] state;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_pwr_ctl #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .pending(pending), .mode_quad(mode_quad), .pred_en(pred_en), .base_sel(base_sel),
    .thr_as(thr_as), .thr_sn(thr_sn), .thr_np(thr_np), .lat_s(lat_s), .lat_n(lat_n),
    .lat_p(lat_p), .benefit(benefit), .state(state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic go_active();
    pending = 1; req_valid = 0;
    for (int i = 0; i < 400 && state != 2'd0; i++) tick();
    tick();
  endtask

  task automatic idle_n(input int n);
    pending = 0; req_valid = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    pending = 1;
    repeat (3) tick();
    chk("R1 state in reset", state, 0);
    chk("R1 ready in reset", req_ready, 1);
    rst_n = 1;
    tick();
    chk("R1 state after reset", state, 0);

    mode_quad = 1;
    for (int i = 0; i < 10; i++) tick();
    chk("R2 pending holds Active", state, 0);
    pending = 0; req_valid = 1;
    for (int i = 0; i < 5; i++) tick();
    chk("R2 request holds Active", state, 0);
    chk("R6 ready in Active", req_ready, 1);
    req_valid = 0;
    tick();
    chk("R8 zero threshold step 1", state, 1);
    tick();
    chk("R8 zero threshold step 2", state, 2);
    tick();
    chk("R8 zero threshold step 3", state, 3);
    go_active();

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          thr_as = CW'(a); thr_sn = CW'(b); thr_np = CW'(c);
          go_active();
          pending = 0;
          for (int k = 1; k <= a + b + c + 6; k++) begin
            int e;
            tick();
            e = (k < a + 1) ? 0 : (k < a + b + 2) ? 1 : (k < a + b + c + 3) ? 2 : 3;
            chk((e < 2) ? "R3 quad demotion" : "R4 quad cascade", state, e);
          end
        end

    thr_as = 0; thr_sn = 0; thr_np = 0;
    for (int s = 1; s < 4; s++)
      for (int l = 0; l < 4; l++) begin
        int n;
        bit held;
        lat_s = CW'(l); lat_n = CW'(l); lat_p = CW'(l);
        go_active();
        idle_n(s);
        chk("R5 reached low level", state, s);
        req_valid = 1;
        #0;
        chk("R6 ready low while asleep", req_ready, 0);
        n = 0; held = 1;
        for (int i = 0; i < 20; i++) begin
          tick();
          n++;
          if (state == 2'd0) break;
          if (state != 2'(s) || req_ready) held = 0;
        end
        chk("R5 wake cycles", n, l + 1);
        chk("R5 low code held during wake", held, 1);
        chk("R6 ready once Active", req_ready, 1);
        req_valid = 0; pending = 1;
        tick();
      end

    lat_n = 2;
    go_active();
    idle_n(2);
    pending = 1;
    tick(); tick(); tick();
    chk("R5 pending wakes from Nap", state, 0);

    mode_quad = 0; lat_s = 1; lat_n = 1; lat_p = 1;
    for (int b = 0; b < 4; b++) begin
      int e;
      base_sel = 2'(b);
      go_active();
      e = (b == 0) ? 1 : b;
      idle_n(1);
      chk("R7 drop to base", state, e);
      idle_n(8);
      chk("R7 stays at base", state, e);
    end
    go_active();

    mode_quad = 1; pred_en = 1; benefit = 20;
    thr_as = 2; thr_sn = 100; thr_np = 100; lat_s = 0; lat_n = 0; lat_p = 0;
    go_active();
    idle_n(30);
    go_active();
    idle_n(1);
    chk("R9 predicted drop to PowerDown", state, 3);
    idle_n(4);
    go_active();
    idle_n(1);
    chk("R10 short gap keeps Active", state, 0);
    idle_n(2);
    chk("R10 short gap normal step", state, 1);
    idle_n(297);
    go_active();
    benefit = 200;
    idle_n(1);
    chk("R10 saturated gap predicts", state, 3);
    idle_n(299);
    go_active();
    benefit = 255;
    idle_n(1);
    chk("R10 gap equal to boundary", state, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule